// File: doc/BRIEF.md
# Code-Density Calibration and Correction Unit for a TDC Fine Code

This block corrects the nonuniform bins of a time-to-digital converter's fine code. A fine code interpolates inside one clock period, and its bins are rarely equal in width. The unit measures each bin on chip. During a calibration pass, hits arrive uncorrelated with the clock, so the number of hits that land in a bin is proportional to that bin's width. The unit counts the hits per code. When a power-of-two total of hits has been seen, it walks the codes in order. From the running sum of counts it computes, for each code, the time of that bin's centre in output units, where the full code range spans one clock period. The results go into a lookup table.

Raw fine codes are always translated through the active table in real time, one cycle after they arrive, and a per-code flag marks bins that received no hits. A calibration is launched either by a start control or by a recalibration request, for example from a temperature monitor. While it runs, the previous table keeps serving hits. The finished table replaces the old one in a single cycle. Until the first calibration completes, the unit assumes equal-width bins. With the default 9-bit code the table holds 512 entries.

The controller is a state machine with four states:
- `CAL_IDLE`: no calibration is running.
- `CAL_ACCUM`: counting hits per code.
- `CAL_BUILD`: one code per cycle, computing the table entry into the inactive bank and zeroing the count.
- `CAL_SWAP`: the inactive bank becomes active.

Its transitions are:
- IDLE→ACCUM on a start or request.
- ACCUM→BUILD on the hit that completes the total.
- BUILD→SWAP after the last code.
- SWAP→IDLE unconditionally.

Top module: `tdc_codedensity_cal`

## Requirements
- R1: After reset, `cal_busy` is 0, `out_missing` is 0 and a hit with code k yields `out_time` = floor((2k+1)·PERIOD / 2^(CODE_W+1)), the centre of k under equal bins.
- R2: A `cal_start` or `recal_req` pulse seen in idle starts accumulation. From the next cycle on, every valid hit adds one to the count of its code.
- R3: Accumulation ends with exactly 2^L hits, where L = min(`cal_log2`, MAX_LOG2) is sampled at the start. Hits after the last counted one do not enter the histogram. `cal_busy` stays high for exactly 2^L + 2^CODE_W + 1 cycles, measured from the cycle after the start.
- R4: Let c_k be the count of code k and S_k = c_0 + … + c_(k-1). For every code with c_k > 0, the new table entry is floor((2·S_k + c_k)·PERIOD / 2^(L+1)), and its missing flag is 0.
- R5: For a code with c_k = 0, the entry equals the entry of code k-1 (0 for code 0), and its missing flag is 1.
- R6: While a calibration runs, hits are corrected with the previous table. The new table is used for every hit presented after `cal_busy` has fallen.
- R7: `out_valid` is high exactly one cycle after each cycle with `hit_valid` high. `out_time` and `out_missing` belong to that hit's code.
- R8: `cal_start` and `recal_req` pulses while `cal_busy` is high neither restart nor extend the calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Pulse: begin a calibration pass |
| recal_req | input | 1 | Pulse: recalibration request (e.g. from a temperature monitor) |
| cal_log2 | input | LOG_IN_W | log2 of the hit total for the pass, clamped to MAX_LOG2 |
| hit_valid | input | 1 | Raw fine code strobe |
| hit_code | input | CODE_W | Raw fine code |
| out_valid | output | 1 | Corrected time strobe |
| out_time | output | $clog2(PERIOD+1) | Corrected bin-centre time, in PERIOD units per clock |
| out_missing | output | 1 | The code's bin received no hits in the active calibration |
| cal_busy | output | 1 | Calibration in progress |

## Verification
The bench uses a 16-code configuration and checks every code against tables that it computes arithmetically in the bench. It runs four hit distributions:
- A uniform spread, which separates correct prefix sums from off-by-one bin indexing.
- A sparse pattern with empty bins, including code 0, which tests the hold-previous rule and the missing flag.
- All hits in one code, followed by stray hits during the build, which shows whether late hits leak into the histogram.
- A request for more hits than the maximum, which tests the clamp.

The first corrected output of each pass is compared with the previous table, which shows whether the bank swap is atomic. A request injected mid-pass must leave the busy duration and the resulting table unchanged.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;
    typedef enum logic [1:0] {
        CAL_IDLE  = 2'd0,
        CAL_ACCUM = 2'd1,
        CAL_BUILD = 2'd2,
        CAL_SWAP  = 2'd3
    } cal_state_e;
endpackage

// File: rtl/cdc_hist.sv
module cdc_hist #(
    parameter int CODE_W = 9,
    parameter int CNT_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_en,
    input  logic [CODE_W-1:0] inc_code,
    input  logic              clr_en,
    input  logic [CODE_W-1:0] idx,
    output logic [CNT_W-1:0]  rd_cnt
);
    localparam int NCODE = 1 << CODE_W;

    logic [CNT_W-1:0] cnt_q [NCODE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCODE; i++) begin
                cnt_q[i] <= '0;
            end
        end else if (inc_en) begin
            cnt_q[inc_code] <= cnt_q[inc_code] + CNT_W'(1);
        end else if (clr_en) begin
            cnt_q[idx] <= '0;
        end
    end

    assign rd_cnt = cnt_q[idx];

    // R2: a counter never wraps while counting hits
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        inc_en |-> (cnt_q[inc_code] != {CNT_W{1'b1}}));

    // R3: increments and clears never coincide
    a_r3_no_mixed_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_en && clr_en));
endmodule

// File: rtl/cdc_ctl.sv
module cdc_ctl
    import tdc_cal_pkg::*;
#(
    parameter int CODE_W   = 9,
    parameter int MAX_LOG2 = 16,
    parameter int CNT_W    = MAX_LOG2 + 1,
    parameter int LOG_IN_W = 5,
    parameter int PERIOD   = 5000,
    parameter int TIME_W   = $clog2(PERIOD + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [LOG_IN_W-1:0] cal_log2_i,
    input  logic                hit_valid_i,
    input  logic [CODE_W-1:0]   hit_code_i,
    input  logic [CNT_W-1:0]    cnt_i,
    output logic                busy_o,
    output logic                inc_en_o,
    output logic [CODE_W-1:0]   inc_code_o,
    output logic [CODE_W-1:0]   idx_o,
    output logic                clr_en_o,
    output logic                wr_en_o,
    output logic [TIME_W-1:0]   wr_time_o,
    output logic                wr_miss_o,
    output logic                swap_o
);
    localparam int NCODE  = 1 << CODE_W;
    localparam int LQ_W   = $clog2(MAX_LOG2 + 1);
    localparam int SH_W   = LQ_W + 1;
    localparam int NUM_W  = CNT_W + 1;
    localparam int PER_W  = $clog2(PERIOD + 1);
    localparam int PROD_W = NUM_W + PER_W;

    cal_state_e         state_q, state_d;
    logic [LQ_W-1:0]    log2_q;
    logic [CNT_W-1:0]   hit_cnt_q;
    logic [CNT_W-1:0]   total_m1;
    logic [CODE_W-1:0]  idx_q;
    logic [CNT_W-1:0]   cum_q;
    logic [TIME_W-1:0]  prev_q;
    logic [NUM_W-1:0]   num;
    logic [PROD_W-1:0]  prod;
    logic [SH_W-1:0]    sh;
    logic [TIME_W-1:0]  center;
    logic [TIME_W-1:0]  entry;
    logic               last_hit;

    assign total_m1 = (CNT_W'(1) << log2_q) - CNT_W'(1);
    assign last_hit = (hit_cnt_q == total_m1);

    // bin-centre arithmetic: (2*S_k + c_k) * PERIOD / 2^(L+1)
    assign num    = {cum_q, 1'b0} + NUM_W'(cnt_i);
    assign prod   = PROD_W'(num) * PROD_W'(PERIOD);
    assign sh     = SH_W'(log2_q) + SH_W'(1);
    assign center = TIME_W'(prod >> sh);
    assign entry  = (cnt_i == '0) ? prev_q : center;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_IDLE:  if (start_i) state_d = CAL_ACCUM;
            CAL_ACCUM: if (hit_valid_i && last_hit) state_d = CAL_BUILD;
            CAL_BUILD: if (idx_q == CODE_W'(NCODE - 1)) state_d = CAL_SWAP;
            CAL_SWAP:  state_d = CAL_IDLE;
            default:   state_d = CAL_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log2_q    <= '0;
            hit_cnt_q <= '0;
            idx_q     <= '0;
            cum_q     <= '0;
            prev_q    <= '0;
        end else begin
            unique case (state_q)
                CAL_IDLE: begin
                    if (start_i) begin
                        if (int'(cal_log2_i) > MAX_LOG2) begin
                            log2_q <= LQ_W'(MAX_LOG2);
                        end else begin
                            log2_q <= LQ_W'(cal_log2_i);
                        end
                        hit_cnt_q <= '0;
                        idx_q     <= '0;
                        cum_q     <= '0;
                        prev_q    <= '0;
                    end
                end
                CAL_ACCUM: begin
                    if (hit_valid_i) hit_cnt_q <= hit_cnt_q + CNT_W'(1);
                end
                CAL_BUILD: begin
                    idx_q  <= idx_q + CODE_W'(1);
                    cum_q  <= cum_q + cnt_i;
                    prev_q <= entry;
                end
                CAL_SWAP: begin
                    idx_q <= '0;
                end
                default: begin
                    idx_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o     = 1'b0;
        inc_en_o   = 1'b0;
        clr_en_o   = 1'b0;
        wr_en_o    = 1'b0;
        swap_o     = 1'b0;
        unique case (state_q)
            CAL_IDLE:  busy_o = 1'b0;
            CAL_ACCUM: begin
                busy_o   = 1'b1;
                inc_en_o = hit_valid_i;
            end
            CAL_BUILD: begin
                busy_o   = 1'b1;
                clr_en_o = 1'b1;
                wr_en_o  = 1'b1;
            end
            CAL_SWAP: begin
                busy_o = 1'b1;
                swap_o = 1'b1;
            end
            default: busy_o = 1'b0;
        endcase
    end

    assign inc_code_o = hit_code_i;
    assign idx_o      = idx_q;
    assign wr_time_o  = entry;
    assign wr_miss_o  = (cnt_i == '0);

    // R3: the hit counter never passes the programmed total
    a_r3_hit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_ACCUM) |-> (hit_cnt_q <= total_m1));

    // R4: entries written during a build never decrease
    a_r4_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && idx_q != '0) |-> (wr_time_o >= prev_q));

    // R5: an empty bin repeats the previous entry
    a_r5_hold_previous: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_miss_o) |-> (wr_time_o == prev_q));

    // R8: accumulation is entered only from idle
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_BUILD || state_q == CAL_SWAP) |=> (state_q != CAL_ACCUM));
endmodule

// File: rtl/cdc_lut.sv
module cdc_lut #(
    parameter int CODE_W = 9,
    parameter int PERIOD = 5000,
    parameter int TIME_W = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_idx,
    input  logic [TIME_W-1:0] wr_time,
    input  logic              wr_miss,
    input  logic              swap,
    input  logic              rd_en,
    input  logic [CODE_W-1:0] rd_code,
    output logic              out_valid,
    output logic [TIME_W-1:0] out_time,
    output logic              out_miss
);
    localparam int NCODE = 1 << CODE_W;
    localparam int PER_W = $clog2(PERIOD + 1);
    localparam int FB_W  = CODE_W + 1 + PER_W;

    logic [TIME_W-1:0] bank_t [0:1][0:NCODE-1];
    logic              bank_m [0:1][0:NCODE-1];
    logic              sel_q;
    logic              loaded_q;
    logic              wsel;
    logic [FB_W-1:0]   fb_prod;
    logic [TIME_W-1:0] fb_time;

    assign wsel    = ~sel_q;
    assign fb_prod = FB_W'({rd_code, 1'b1}) * FB_W'(PERIOD);
    assign fb_time = TIME_W'(fb_prod >> (CODE_W + 1));

    // shadow bank writes
    always_ff @(posedge clk) begin
        if (wr_en) begin
            bank_t[wsel][wr_idx] <= wr_time;
            bank_m[wsel][wr_idx] <= wr_miss;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= 1'b0;
            loaded_q  <= 1'b0;
            out_valid <= 1'b0;
            out_time  <= '0;
            out_miss  <= 1'b0;
        end else begin
            if (swap) begin
                sel_q    <= wsel;
                loaded_q <= 1'b1;
            end
            out_valid <= rd_en;
            if (rd_en) begin
                if (loaded_q) begin
                    out_time <= bank_t[sel_q][rd_code];
                    out_miss <= bank_m[sel_q][rd_code];
                end else begin
                    out_time <= fb_time;
                    out_miss <= 1'b0;
                end
            end
        end
    end

    // R6: the active bank changes only on a swap
    a_r6_atomic_swap: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(sel_q));

    // R7: one corrected output per hit, one cycle later
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> out_valid);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !out_valid);
endmodule

// File: rtl/tdc_codedensity_cal.sv
module tdc_codedensity_cal #(
    parameter int CODE_W   = 9,
    parameter int MAX_LOG2 = 16,
    parameter int LOG_IN_W = 5,
    parameter int PERIOD   = 5000,
    localparam int CNT_W   = MAX_LOG2 + 1,
    localparam int TIME_W  = $clog2(PERIOD + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cal_start,
    input  logic                recal_req,
    input  logic [LOG_IN_W-1:0] cal_log2,
    input  logic                hit_valid,
    input  logic [CODE_W-1:0]   hit_code,
    output logic                out_valid,
    output logic [TIME_W-1:0]   out_time,
    output logic                out_missing,
    output logic                cal_busy
);
    logic              start_any;
    logic              inc_en;
    logic [CODE_W-1:0] inc_code;
    logic [CODE_W-1:0] idx;
    logic              clr_en;
    logic [CNT_W-1:0]  cnt;
    logic              wr_en;
    logic [TIME_W-1:0] wr_time;
    logic              wr_miss;
    logic              swap;

    assign start_any = cal_start | recal_req;

    cdc_ctl #(
        .CODE_W  (CODE_W),
        .MAX_LOG2(MAX_LOG2),
        .CNT_W   (CNT_W),
        .LOG_IN_W(LOG_IN_W),
        .PERIOD  (PERIOD),
        .TIME_W  (TIME_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_any),
        .cal_log2_i (cal_log2),
        .hit_valid_i(hit_valid),
        .hit_code_i (hit_code),
        .cnt_i      (cnt),
        .busy_o     (cal_busy),
        .inc_en_o   (inc_en),
        .inc_code_o (inc_code),
        .idx_o      (idx),
        .clr_en_o   (clr_en),
        .wr_en_o    (wr_en),
        .wr_time_o  (wr_time),
        .wr_miss_o  (wr_miss),
        .swap_o     (swap)
    );

    cdc_hist #(
        .CODE_W(CODE_W),
        .CNT_W (CNT_W)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (inc_en),
        .inc_code(inc_code),
        .clr_en  (clr_en),
        .idx     (idx),
        .rd_cnt  (cnt)
    );

    cdc_lut #(
        .CODE_W(CODE_W),
        .PERIOD(PERIOD),
        .TIME_W(TIME_W)
    ) u_lut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (idx),
        .wr_time  (wr_time),
        .wr_miss  (wr_miss),
        .swap     (swap),
        .rd_en    (hit_valid),
        .rd_code  (hit_code),
        .out_valid(out_valid),
        .out_time (out_time),
        .out_miss (out_missing)
    );
endmodule

// File: tb/tdc_codedensity_cal_bench.sv
module tdc_codedensity_cal_bench;
    localparam int CODE_W   = 4;
    localparam int MAX_LOG2 = 8;
    localparam int LOG_IN_W = 5;
    localparam int PERIOD   = 5000;
    localparam int NCODE    = 1 << CODE_W;
    localparam int TIME_W   = $clog2(PERIOD + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cal_start = 1'b0;
    logic                recal_req = 1'b0;
    logic [LOG_IN_W-1:0] cal_log2 = '0;
    logic                hit_valid = 1'b0;
    logic [CODE_W-1:0]   hit_code = '0;
    logic                out_valid;
    logic [TIME_W-1:0]   out_time;
    logic                out_missing;
    logic                cal_busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int cnt_pat [NCODE];
    int exp_t   [NCODE];
    int exp_m   [NCODE];
    int old_t   [NCODE];
    int seq     [512];
    int seq_len;

    always #2 clk = ~clk;

    tdc_codedensity_cal #(
        .CODE_W  (CODE_W),
        .MAX_LOG2(MAX_LOG2),
        .LOG_IN_W(LOG_IN_W),
        .PERIOD  (PERIOD)
    ) u_tdc_codedensity_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_start  (cal_start),
        .recal_req  (recal_req),
        .cal_log2   (cal_log2),
        .hit_valid  (hit_valid),
        .hit_code   (hit_code),
        .out_valid  (out_valid),
        .out_time   (out_time),
        .out_missing(out_missing),
        .cal_busy   (cal_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic build_exp(input int lreq);
        int leff;
        int cum;
        int prev;
        leff = (lreq > MAX_LOG2) ? MAX_LOG2 : lreq;
        cum = 0;
        prev = 0;
        for (int k = 0; k < NCODE; k++) begin
            if (cnt_pat[k] == 0) begin
                exp_t[k] = prev;
                exp_m[k] = 1;
            end else begin
                exp_t[k] = ((2 * cum + cnt_pat[k]) * PERIOD) >> (leff + 1);
                exp_m[k] = 0;
            end
            prev = exp_t[k];
            cum += cnt_pat[k];
        end
    endtask

    task automatic sweep(input string req);
        for (int k = 0; k < NCODE; k++) begin
            @(negedge clk);
            hit_valid = 1'b1;
            hit_code  = CODE_W'(k);
            @(negedge clk);
            chk(out_valid == 1'b1, {req, " R7 valid"}, int'(out_valid), 1);
            chk(int'(out_time) == exp_t[k], {req, " time"}, int'(out_time), exp_t[k]);
            chk(int'(out_missing) == exp_m[k], {req, " missing"}, int'(out_missing), exp_m[k]);
            hit_valid = 1'b0;
            @(negedge clk);
            chk(out_valid == 1'b0, "R7 idle", int'(out_valid), 0);
        end
        for (int k = 0; k < NCODE; k++) old_t[k] = exp_t[k];
    endtask

    task automatic run_cal(input int lreq, input int recal_at, input int extra, input bit use_req);
        int cyc;
        int busy_cnt;
        cyc = 0;
        busy_cnt = 0;
        @(negedge clk);
        cal_log2 = LOG_IN_W'(lreq);
        if (use_req) recal_req = 1'b1;
        else cal_start = 1'b1;
        while (1) begin
            @(negedge clk);
            cal_start = 1'b0;
            recal_req = 1'b0;
            if (cyc == 1) begin
                chk(int'(out_time) == old_t[seq[0]], "R6 old table during pass",
                    int'(out_time), old_t[seq[0]]);
            end
            if (!cal_busy) break;
            busy_cnt++;
            if (cyc < seq_len) begin
                hit_valid = 1'b1;
                hit_code  = CODE_W'(seq[cyc]);
            end else if (cyc < seq_len + extra) begin
                hit_valid = 1'b1;
                hit_code  = CODE_W'(3);
            end else begin
                hit_valid = 1'b0;
            end
            if (cyc == recal_at) begin
                recal_req = 1'b1;
                cal_start = 1'b1;
            end
            cyc++;
        end
        hit_valid = 1'b0;
        chk(busy_cnt == seq_len + NCODE + 1, "R3 R8 busy duration", busy_cnt, seq_len + NCODE + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cal_busy == 1'b0, "R1 busy after reset", int'(cal_busy), 0);
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        for (int k = 0; k < NCODE; k++) begin
            exp_t[k] = ((2 * k + 1) * PERIOD) >> (CODE_W + 1);
            exp_m[k] = 0;
        end
        sweep("R1");

        // uniform distribution, interleaved codes, started by cal_start
        for (int k = 0; k < NCODE; k++) cnt_pat[k] = 4;
        seq_len = 64;
        for (int i = 0; i < seq_len; i++) seq[i] = i % NCODE;
        run_cal(6, -1, 0, 1'b0);
        build_exp(6);
        sweep("R2 R4 R6");

        // sparse distribution with empty bins, started by recal_req, request mid-pass
        cnt_pat = '{0, 3, 0, 0, 5, 2, 1, 0, 4, 4, 3, 0, 2, 6, 2, 0};
        seq_len = 0;
        for (int k = 0; k < NCODE; k++) begin
            for (int j = 0; j < cnt_pat[k]; j++) begin
                seq[seq_len] = k;
                seq_len++;
            end
        end
        run_cal(5, 10, 0, 1'b1);
        build_exp(5);
        sweep("R5 R4 R8");

        // all hits in one code, stray hits during the build
        for (int k = 0; k < NCODE; k++) cnt_pat[k] = 0;
        cnt_pat[7] = 16;
        seq_len = 16;
        for (int i = 0; i < seq_len; i++) seq[i] = 7;
        run_cal(4, -1, 3, 1'b0);
        build_exp(4);
        sweep("R3 R5 late hits");

        // requested total above the maximum is clamped
        for (int k = 0; k < NCODE; k++) cnt_pat[k] = (k % 2 == 0) ? 24 : 8;
        seq_len = 0;
        for (int k = 0; k < NCODE; k++) begin
            for (int j = 0; j < cnt_pat[k]; j++) begin
                seq[seq_len] = k;
                seq_len++;
            end
        end
        run_cal(20, -1, 0, 1'b0);
        build_exp(20);
        sweep("R3 clamp R4");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule